// File: doc/BRIEF.md
# Safety Fault Reaction Supervisor

This block is the central supervisor for a chip's fault-handling path. It watches two vectors of fault flags: critical faults and non-critical faults. Both arrive already latched, and each flag stays high until an outside agent clears it. From these flags the block runs a small state machine with the states NORMAL, CONFIG, ALARM and FAULT. It raises the reactions to the rest of the system:
- a sticky alarm interrupt;
- a sticky non-maskable interrupt;
- a one-cycle request for a short or a long functional reset.

Each non-critical fault has an enable bit and a timeout-enable bit. An enabled fault whose timeout is enabled gets a grace period in ALARM before it escalates. The grace period is set by a programmable down-counter. Any other enabled non-critical fault, and any critical fault, escalates straight to FAULT. Each critical fault carries its own reset reaction. When several critical faults hit together, the worst programmed reaction is issued. The way out of FAULT depends on which classes of fault are still pending.

Top module: `fault_supervisor`

## Requirements
- R1: After reset `state_o` reads NORMAL, and `alarm_irq_o`, `nmi_o`, `short_rst_o` and `long_rst_o` are all 0. The state codes are NORMAL=0, CONFIG=1, ALARM=2, FAULT=3.
- R2: In NORMAL, the state changes on the next clock edge, with this priority:
  - a critical fault, or an enabled non-critical fault whose timeout-enable bit is 0, moves to FAULT;
  - otherwise an enabled non-critical fault whose timeout-enable bit is 1 moves to ALARM;
  - critical and non-critical faults in the same cycle give FAULT.
- R3: A non-critical fault whose enable bit is 0 has no effect on the state.
- R4: On entry to ALARM the counter loads `alarm_timeout_i` = T. If at least one enabled non-critical fault stays pending and nothing else escalates, the block stays in ALARM for T+1 cycles and then enters FAULT.
- R5: In ALARM, either of the following moves to FAULT at the next edge:
  - a critical fault;
  - an enabled non-critical fault whose timeout is disabled.

  Otherwise, when no enabled non-critical fault is pending, ALARM returns to NORMAL. Recovery in the same cycle as expiry wins.
- R6: FAULT holds while any critical fault, or any timeout-disabled enabled non-critical fault, is pending. If only timed non-critical faults remain, it goes to ALARM, unless the alarm timeout has already elapsed since the last NORMAL, in which case it holds FAULT. With nothing pending it goes to NORMAL.
- R7: On entry to FAULT, the block issues a one-cycle reset request in the same cycle as the new state. The request is the most severe reaction among the critical faults that are asserted. Each critical fault has a 2-bit field in `crit_react_i`: 00 none, 01 short, 1x long. Long outranks short, which outranks none. Entry through non-critical faults alone issues no request.
- R8: While in FAULT, a critical fault that newly rises issues its programmed reset request at once (worst case among those rising). A critical fault that stays high issues nothing more.
- R9: `alarm_irq_o` sets on entry to ALARM and stays set until `alarm_clr_i`. A set in the same cycle as a clear wins.
- R10: `nmi_o` sets on entry to FAULT and stays set until `nmi_clr_i`. A set in the same cycle as a clear wins.
- R11: From NORMAL with no fault demanding a transition, `cfg_req_i` enters CONFIG. CONFIG ignores all faults and returns to NORMAL when `cfg_req_i` drops.
- R12: The two reset requests are never high together, and either one is only ever high while `state_o` reads FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Safe clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_i | input | N_CRIT | Latched critical fault flags |
| ncrit_i | input | N_NCRIT | Latched non-critical fault flags |
| ncrit_en_i | input | N_NCRIT | Per non-critical fault enable |
| ncrit_to_en_i | input | N_NCRIT | Per non-critical fault timeout enable |
| alarm_timeout_i | input | TO_W | Alarm grace period, loaded on ALARM entry |
| crit_react_i | input | 2*N_CRIT | Per critical fault reaction: 00 none, 01 short, 1x long |
| cfg_req_i | input | 1 | Request to hold CONFIG |
| alarm_clr_i | input | 1 | Clears the alarm interrupt status |
| nmi_clr_i | input | 1 | Clears the NMI status |
| state_o | output | 2 | Current state code |
| alarm_irq_o | output | 1 | Sticky alarm interrupt |
| nmi_o | output | 1 | Sticky non-maskable interrupt |
| short_rst_o | output | 1 | One-cycle short functional reset request |
| long_rst_o | output | 1 | One-cycle long functional reset request |

## Verification
The assertions assume the fault flags are synchronous to the safe clock and change only between edges. They also assume configuration inputs such as the timeout value may change at any time and take effect only at the edge where they are sampled. The stimulus drives every input shortly after each rising edge. It keeps fault patterns sparse and holds them for several cycles, so that ALARM periods run to expiry as well as recover early. The fault-while-in-CONFIG case is reached by raising faults only after CONFIG has been entered.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_CONFIG = 2'd1,
    ST_ALARM  = 2'd2,
    ST_FAULT  = 2'd3
  } fsup_state_e;

  typedef enum logic [1:0] {
    RX_NONE  = 2'd0,
    RX_SHORT = 2'd1,
    RX_LONG  = 2'd2
  } fsup_react_e;
endpackage

// File: rtl/fsup_sev_reduce.sv
module fsup_sev_reduce
  import fsup_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]   mask_i,
  input  logic [2*N-1:0] react_i,
  output fsup_react_e    sev_o
);
  logic [N-1:0] is_long, is_short;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign is_long[g]  = mask_i[g] & react_i[2*g+1];
    assign is_short[g] = mask_i[g] & ~react_i[2*g+1] & react_i[2*g];
  end

  always_comb begin
    if (|is_long)       sev_o = RX_LONG;
    else if (|is_short) sev_o = RX_SHORT;
    else                sev_o = RX_NONE;
  end
endmodule

// File: rtl/fsup_alarm_timer.sv
module fsup_alarm_timer #(
  parameter int unsigned TO_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TO_W-1:0] load_val_i,
  input  logic            run_i,
  output logic            zero_o
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R4
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fsup_state_ctl.sv
module fsup_state_ctl
  import fsup_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        crit_any_i,
  input  logic        nc_direct_i,
  input  logic        nc_timed_i,
  input  logic        nc_any_i,
  input  logic        cfg_req_i,
  input  logic        tmr_zero_i,
  output fsup_state_e state_q_o,
  output fsup_state_e state_d_o
);
  fsup_state_e st_q, st_d;
  logic        elapsed_q;
  logic        escalate;

  assign escalate = crit_any_i | nc_direct_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORMAL: begin
        if (escalate)        st_d = ST_FAULT;
        else if (nc_timed_i) st_d = ST_ALARM;
        else if (cfg_req_i)  st_d = ST_CONFIG;
      end
      ST_CONFIG: if (!cfg_req_i) st_d = ST_NORMAL;
      ST_ALARM: begin
        if (escalate)        st_d = ST_FAULT;
        else if (!nc_any_i)  st_d = ST_NORMAL;  // recovery beats expiry
        else if (tmr_zero_i) st_d = ST_FAULT;
      end
      ST_FAULT: begin
        if (escalate || (nc_timed_i && elapsed_q)) st_d = ST_FAULT;
        else if (nc_timed_i)                       st_d = ST_ALARM;
        else                                       st_d = ST_NORMAL;
      end
      default: st_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_NORMAL;
      elapsed_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_NORMAL)                     elapsed_q <= 1'b0;
      else if (st_q == ST_ALARM && tmr_zero_i)   elapsed_q <= 1'b1;
    end
  end

  assign state_q_o = st_q;
  assign state_d_o = st_d;

  // R2
  crit_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_NORMAL && crit_any_i) |=> (st_q == ST_FAULT));
  // R11
  config_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CONFIG) |=> (st_q == ST_CONFIG || st_q == ST_NORMAL));
  // R6
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FAULT && crit_any_i) |=> (st_q == ST_FAULT));
  // R5
  alarm_recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ALARM && !escalate && !nc_any_i) |=> (st_q == ST_NORMAL));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned N_CRIT  = 8,
  parameter int unsigned N_NCRIT = 8,
  parameter int unsigned TO_W    = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CRIT-1:0]     crit_i,
  input  logic [N_NCRIT-1:0]    ncrit_i,
  input  logic [N_NCRIT-1:0]    ncrit_en_i,
  input  logic [N_NCRIT-1:0]    ncrit_to_en_i,
  input  logic [TO_W-1:0]       alarm_timeout_i,
  input  logic [2*N_CRIT-1:0]   crit_react_i,
  input  logic                  cfg_req_i,
  input  logic                  alarm_clr_i,
  input  logic                  nmi_clr_i,
  output logic [1:0]            state_o,
  output logic                  alarm_irq_o,
  output logic                  nmi_o,
  output logic                  short_rst_o,
  output logic                  long_rst_o
);
  logic [N_NCRIT-1:0] nc_act;
  logic [N_CRIT-1:0]  crit_q, crit_rise;
  logic               tmr_zero, tmr_load, enter_alarm, enter_fault;
  fsup_state_e        st_q, st_d;
  fsup_react_e        sev_all, sev_rise, sev_sel;
  logic               irq_q, nmi_q, srst_q, lrst_q;

  assign nc_act    = ncrit_i & ncrit_en_i;
  assign crit_rise = crit_i & ~crit_q;

  fsup_state_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .crit_any_i  (|crit_i),
    .nc_direct_i (|(nc_act & ~ncrit_to_en_i)),
    .nc_timed_i  (|(nc_act & ncrit_to_en_i)),
    .nc_any_i    (|nc_act),
    .cfg_req_i   (cfg_req_i),
    .tmr_zero_i  (tmr_zero),
    .state_q_o   (st_q),
    .state_d_o   (st_d)
  );

  assign enter_alarm = (st_d == ST_ALARM) && (st_q != ST_ALARM);
  assign enter_fault = (st_d == ST_FAULT) && (st_q != ST_FAULT);
  assign tmr_load    = enter_alarm;

  fsup_alarm_timer #(.TO_W(TO_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (alarm_timeout_i),
    .run_i      (st_q == ST_ALARM),
    .zero_o     (tmr_zero)
  );

  fsup_sev_reduce #(.N(N_CRIT)) u_sev_all (
    .mask_i (crit_i),
    .react_i(crit_react_i),
    .sev_o  (sev_all)
  );

  fsup_sev_reduce #(.N(N_CRIT)) u_sev_rise (
    .mask_i (crit_rise),
    .react_i(crit_react_i),
    .sev_o  (sev_rise)
  );

  always_comb begin
    if (enter_fault)                                   sev_sel = sev_all;
    else if (st_q == ST_FAULT && st_d == ST_FAULT)     sev_sel = sev_rise;
    else                                               sev_sel = RX_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_q <= '0;
      irq_q  <= 1'b0;
      nmi_q  <= 1'b0;
      srst_q <= 1'b0;
      lrst_q <= 1'b0;
    end else begin
      crit_q <= crit_i;
      irq_q  <= enter_alarm | (irq_q & ~alarm_clr_i);
      nmi_q  <= enter_fault | (nmi_q & ~nmi_clr_i);
      srst_q <= (sev_sel == RX_SHORT);
      lrst_q <= (sev_sel == RX_LONG);
    end
  end

  assign state_o     = st_q;
  assign alarm_irq_o = irq_q;
  assign nmi_o       = nmi_q;
  assign short_rst_o = srst_q;
  assign long_rst_o  = lrst_q;

  // R12
  rst_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({srst_q, lrst_q}));
  // R12
  rst_in_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_q || lrst_q) |-> (st_q == ST_FAULT));
  // R9
  irq_on_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ALARM && $past(st_q) != ST_ALARM) |-> irq_q);
  // R10
  nmi_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FAULT && $past(st_q) != ST_FAULT) |-> nmi_q);
  // R10
  nmi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_q && !nmi_clr_i) |=> nmi_q);
endmodule

// File: tb/sim_fault_supervisor.sv
`timescale 1ns/1ps
module sim_fault_supervisor;
  localparam int NC = 8, NN = 8, TW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NC-1:0]   c = '0;
  logic [NN-1:0]   n = '0, en = '0, toen = '0;
  logic [TW-1:0]   tmo = '0;
  logic [2*NC-1:0] react = '0;
  logic cfg = 0, aclr = 0, nclr = 0;
  logic [1:0] st_o;
  logic irq_o, nmi_o, srst_o, lrst_o;

  fault_supervisor #(.N_CRIT(NC), .N_NCRIT(NN), .TO_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .crit_i(c), .ncrit_i(n), .ncrit_en_i(en),
    .ncrit_to_en_i(toen), .alarm_timeout_i(tmo), .crit_react_i(react),
    .cfg_req_i(cfg), .alarm_clr_i(aclr), .nmi_clr_i(nclr),
    .state_o(st_o), .alarm_irq_o(irq_o), .nmi_o(nmi_o),
    .short_rst_o(srst_o), .long_rst_o(lrst_o));

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state (codes: 0 NORMAL, 1 CONFIG, 2 ALARM, 3 FAULT)
  int unsigned m_st = 0, m_cnt = 0;
  bit m_el = 0, m_irq = 0, m_nmi = 0, m_s = 0, m_l = 0;
  logic [NC-1:0] m_cq = '0;

  function automatic int worst(logic [NC-1:0] m, logic [2*NC-1:0] r);
    int w = 0;
    for (int i = 0; i < NC; i++)
      if (m[i]) begin
        if (r[2*i+1]) w = 2;
        else if (r[2*i] && w < 1) w = 1;
      end
    return w;
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  task automatic cyc(string tag);
    int unsigned nst, ncnt, sev;
    bit ca, dir, tim, any, nel;
    ca  = |c;
    dir = |(n & en & ~toen);
    tim = |(n & en & toen);
    any = |(n & en);
    nst = m_st;
    case (m_st)
      0: nst = (ca || dir) ? 3 : tim ? 2 : cfg ? 1 : 0;
      1: nst = cfg ? 1 : 0;
      2: nst = (ca || dir) ? 3 : !any ? 0 : (m_cnt == 0) ? 3 : 2;
      default: nst = (ca || dir || (tim && m_el)) ? 3 : tim ? 2 : 0;
    endcase
    ncnt = m_cnt;
    if (nst == 2 && m_st != 2) ncnt = tmo;
    else if (m_st == 2 && m_cnt != 0) ncnt = m_cnt - 1;
    nel = m_el;
    if (nst == 0) nel = 0;
    else if (m_st == 2 && m_cnt == 0) nel = 1;
    sev = 0;
    if (nst == 3 && m_st != 3) sev = worst(c, react);
    else if (nst == 3 && m_st == 3) sev = worst(c & ~m_cq, react);
    @(posedge clk);
    m_irq = (nst == 2 && m_st != 2) ? 1'b1 : (m_irq & ~aclr);
    m_nmi = (nst == 3 && m_st != 3) ? 1'b1 : (m_nmi & ~nclr);
    m_s = (sev == 1);
    m_l = (sev == 2);
    m_st = nst; m_cnt = ncnt; m_el = nel; m_cq = c;
    #1;
    chk(tag, "state", st_o, m_st);
    chk(tag, "alarm_irq", irq_o, m_irq);
    chk(tag, "nmi", nmi_o, m_nmi);
    chk(tag, "short_rst", srst_o, m_s);
    chk(tag, "long_rst", lrst_o, m_l);
  endtask

  task automatic idle_all();
    c = '0; n = '0; cfg = 0; aclr = 1; nclr = 1;
    repeat (3) cyc("idle");
    aclr = 0; nclr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    #1;
    // R1: reset state
    chk("R1", "state", st_o, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "nmi", nmi_o, 0);
    chk("R1", "rst", {srst_o, lrst_o}, 0);
    #13 rst_n = 1;
    @(posedge clk); #1;

    en = '1; toen = '1; tmo = 3;
    react = 16'b00_00_00_00_00_00_10_01; // c0 short, c1 long

    // R2: timed non-critical fault -> ALARM
    n = 8'h01; cyc("R2");
    chk("R2", "state code ALARM", st_o, 2);
    chk("R9", "irq set", irq_o, 1);
    // R4: T=3 -> three more cycles in ALARM, fourth enters FAULT
    repeat (3) cyc("R4");
    chk("R4", "still ALARM", st_o, 2);
    cyc("R4");
    chk("R4", "expired FAULT", st_o, 3);
    chk("R10", "nmi set", nmi_o, 1);
    chk("R7", "no reset from ncf", {srst_o, lrst_o}, 0);
    // R6: elapsed -> timed pending holds FAULT
    repeat (2) cyc("R6");
    chk("R6", "elapsed hold", st_o, 3);
    n = '0; cyc("R6");
    chk("R6", "all clear NORMAL", st_o, 0);
    // R9/R10 sticky then clear
    chk("R9", "irq sticky", irq_o, 1);
    aclr = 1; nclr = 1; cyc("R9");
    chk("R9", "irq cleared", irq_o, 0);
    chk("R10", "nmi cleared", nmi_o, 0);
    aclr = 0; nclr = 0;

    // R3: disabled non-critical fault ignored
    en = 8'hFE; n = 8'h01; toen = 8'h00;
    repeat (3) cyc("R3");
    chk("R3", "ignored", st_o, 0);
    n = '0; en = '1; toen = '1;

    // R2: critical + timed ncf same cycle -> FAULT with worst reaction
    c = 8'h03; n = 8'h04; cyc("R2");
    chk("R2", "FAULT wins", st_o, 3);
    chk("R7", "long wins", lrst_o, 1);
    chk("R7", "short low", srst_o, 0);
    cyc("R7");
    chk("R7", "pulse one cycle", lrst_o, 0);
    // R6: crit clears, timed ncf remains, not elapsed -> ALARM
    c = '0; cyc("R6");
    chk("R6", "back to ALARM", st_o, 2);
    n = '0; cyc("R5");
    chk("R5", "recovered NORMAL", st_o, 0);
    idle_all();

    // R5: ALARM escalation by critical fault; R8: new crit in FAULT
    tmo = 20; n = 8'h10; cyc("R5");
    c = 8'h04; cyc("R5");
    chk("R5", "crit in ALARM", st_o, 3);
    chk("R7", "no reaction bit2", {srst_o, lrst_o}, 0);
    c = 8'h05; cyc("R8");
    chk("R8", "short on rise", srst_o, 1);
    cyc("R8");
    chk("R8", "no repeat", srst_o, 0);
    // R5: direct ncf in ALARM
    c = '0; cyc("R5");
    chk("R5", "alarm again", st_o, 2);
    toen = 8'hEF; cyc("R5");
    chk("R5", "direct ncf", st_o, 3);
    toen = '1; n = '0; idle_all();

    // R11: CONFIG ignores faults
    cfg = 1; cyc("R11");
    chk("R11", "CONFIG", st_o, 1);
    c = 8'h02; repeat (2) cyc("R11");
    chk("R11", "faults ignored", st_o, 1);
    cfg = 0; cyc("R11");
    chk("R11", "exit NORMAL", st_o, 0);
    cyc("R11");
    chk("R11", "then FAULT", st_o, 3);
    chk("R7", "level crit long", lrst_o, 1);
    idle_all();

    // random phase
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 5 == 0) c = ($urandom % 3 == 0) ? NC'(1 << ($urandom % NC)) : '0;
      if ($urandom % 4 == 0) n = ($urandom % 2 == 0) ? NN'($urandom) & NN'($urandom) : '0;
      if ($urandom % 40 == 0) en = NN'($urandom) | NN'($urandom);
      if ($urandom % 40 == 0) toen = NN'($urandom) | NN'($urandom);
      if ($urandom % 30 == 0) react = 16'($urandom);
      if ($urandom % 10 == 0) tmo = $urandom % 12;
      cfg  = ($urandom % 8 == 0);
      aclr = ($urandom % 6 == 0);
      nclr = ($urandom % 6 == 0);
      cyc("R12");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule